// File: doc/BRIEF.md
# I2C Interface Status Flag Controller

This block keeps the status and interrupt flags of a byte-oriented I2C controller. The bit-level engine beside it reports bus events as one-cycle strobes: end of a byte, the level seen in the acknowledge clock, the last data bit, arbitration loss, and address-compare results. The block applies fixed set and clear rules to its eight flags from these strobes, from CPU writes to the data shift register and from CPU writes to the writable flags. START and STOP conditions are found inside the block. The raw SCL and SDA lines pass through a synchroniser chain, and edges are detected in the system clock domain.

There are two groups of four flags. The low group is read-only to the CPU and holds the arbitration-lost, address-hit, general-call and last-received-bit flags. The high group is read/write and holds the master bit, the direction bit (1 = transmit), the bus-busy flag and an active-low interrupt-pending bit. While the interrupt-pending bit is 0, the block asks the clock generator to keep SCL low. Its falling transition produces a one-cycle interrupt request.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset the low flags read 4'b0000, the high flags read 4'b1000 (interrupt-pending high, busy, direction and master low), and irq and scl_hold are 0.
- R2: When enabled, a START on the bus (SDA falling while SCL is high) sets busy (hi_flags[2]), and a STOP (SDA rising while SCL is high) clears it. While iface_en is 0, busy stays 0.
- R3: The last-bit flag (lo_flags[3]) is loaded from ack_level on ev_ack when ack_mode is 1, and from rx_bit on ev_rx_last when ack_mode is 0. The strobe of the other mode is ignored. A data shift register write (dsr_wr) clears the flag.
- R4: ev_byte_end drives the interrupt-pending bit (hi_flags[3]) to 0. In the same cycle irq is 1, for exactly one cycle. scl_hold is 1 whenever the enabled block has the pending bit at 0.
- R5: The interrupt-pending bit returns to 1 on dsr_wr, and on any cycle with iface_en at 0.
- R6: ev_arb_lost is accepted only when master (hi_flags[0]) and direction (hi_flags[1]) are both 1. On acceptance it sets lo_flags[0] and clears direction at once, and master clears at the next ev_byte_end. dsr_wr clears lo_flags[0].
- R7: In slave mode (master 0), ev_addr_match sets the address-hit flag (lo_flags[1]) and loads direction from addr_rw. ev_gen_call sets both address-hit and general-call (lo_flags[2]). START or STOP clears general-call, and dsr_wr clears address-hit.
- R8: Direction is cleared by STOP, by start_req while busy is 1 (a blocked START), and in slave mode by START or by ev_ack with ack_level 1 (no acknowledge).
- R9: A wr_hi write loads wr_hi_data into the high flags, bit order {pending, busy, direction, master}. The busy bit is written only when master and direction were both 1 before the write. When a hardware event and a CPU write hit the same flag in one cycle, the hardware event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| iface_en | input | 1 | Interface enable |
| ev_byte_end | input | 1 | Falling edge of the last clock of a byte, acknowledge clock included |
| ev_ack | input | 1 | Acknowledge-clock sample strobe |
| ack_level | input | 1 | SDA level sampled in the acknowledge clock |
| ev_rx_last | input | 1 | Last received data bit strobe |
| rx_bit | input | 1 | Value of that data bit |
| ack_mode | input | 1 | 1 selects acknowledge mode for the last-bit flag |
| ev_arb_lost | input | 1 | Engine saw SDA low while driving high |
| ev_addr_match | input | 1 | Own slave address matched |
| ev_gen_call | input | 1 | General-call address received |
| addr_rw | input | 1 | Read/write bit of the matched address byte |
| start_req | input | 1 | Request to generate a START |
| dsr_wr | input | 1 | CPU write to the data shift register |
| wr_hi | input | 1 | CPU write strobe for the high flags |
| wr_hi_data | input | 4 | Write data {pending, busy, direction, master} |
| lo_flags | output | 4 | {last bit, general call, address hit, arbitration lost} |
| hi_flags | output | 4 | {pending (active low), busy, direction, master} |
| irq | output | 1 | One-cycle interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The hardest situations to reach from the ports are collisions between CPU writes and hardware events on the same flag in the same cycle, and the arbitration-loss path. The first is reached by asserting wr_hi or dsr_wr in the very cycle that ev_byte_end is driven. For the second, the master and direction bits must first be written to 1 so that the loss strobe is accepted. The bench then checks that master survives until a later byte end. START and STOP only come through the synchroniser, so the bench drives the raw lines in legal sequences and waits out the chain latency before it samples.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;

   typedef struct packed {
      logic last_bit;
      logic gcall;
      logic addr_hit;
      logic arb_lost;
   } lo_flags_t;

   typedef struct packed {
      logic pend_n;
      logic busy;
      logic dir_tx;
      logic master;
   } hi_flags_t;

   localparam int FLAG_W = 4;
   localparam hi_flags_t HI_RESET = '{pend_n: 1'b1, busy: 1'b0, dir_tx: 1'b0, master: 1'b0};
   localparam lo_flags_t LO_RESET = '0;

endpackage

// File: rtl/i2c_bus_cond_detect.sv
module i2c_bus_cond_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic start_det,
   output logic stop_det
);

   localparam int LAST = SYNC_STAGES - 1;

   logic [LAST:0] scl_chain;
   logic [LAST:0] sda_chain;
   logic          scl_prev;
   logic          sda_prev;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("i2c_bus_cond_detect: SYNC_STAGES must be at least 2");
      end

      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_in;
                  sda_chain[0] <= sda_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[i] <= 1'b1;
                  sda_chain[i] <= 1'b1;
               end else begin
                  scl_chain[i] <= scl_chain[i-1];
                  sda_chain[i] <= sda_chain[i-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_chain[LAST];
         sda_prev <= sda_chain[LAST];
      end
   end

   // Conditions count only when SCL was high on both sides of the SDA edge.
   always_comb begin
      start_det = scl_prev & scl_chain[LAST] & sda_prev & ~sda_chain[LAST];
      stop_det  = scl_prev & scl_chain[LAST] & ~sda_prev & sda_chain[LAST];
   end

endmodule

// File: rtl/i2c_lo_flag_unit.sv
module i2c_lo_flag_unit
   import i2c_status_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_det,
   input  logic      stop_det,
   input  logic      ack_mode,
   input  logic      ev_ack,
   input  logic      ack_level,
   input  logic      ev_rx_last,
   input  logic      rx_bit,
   input  logic      arb_take,
   input  logic      addr_take,
   input  logic      gcall_take,
   input  logic      dsr_wr,
   output lo_flags_t lo_q
);

   lo_flags_t lo_d;

   always_comb begin
      lo_d = lo_q;
      // CPU side: a data register write clears these; events below override.
      if (dsr_wr) begin
         lo_d.last_bit = 1'b0;
         lo_d.addr_hit = 1'b0;
         lo_d.arb_lost = 1'b0;
      end
      if (ack_mode && ev_ack)        lo_d.last_bit = ack_level;
      if (!ack_mode && ev_rx_last)   lo_d.last_bit = rx_bit;
      if (arb_take)                  lo_d.arb_lost = 1'b1;
      if (start_det || stop_det)     lo_d.gcall    = 1'b0;
      if (addr_take || gcall_take)   lo_d.addr_hit = 1'b1;
      if (gcall_take)                lo_d.gcall    = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_q <= LO_RESET;
      else        lo_q <= lo_d;
   end

endmodule

// File: rtl/i2c_hi_flag_unit.sv
module i2c_hi_flag_unit
   import i2c_status_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      iface_en,
   input  logic      start_det,
   input  logic      stop_det,
   input  logic      start_req,
   input  logic      ev_byte_end,
   input  logic      no_ack,
   input  logic      arb_take,
   input  logic      addr_take,
   input  logic      addr_rw,
   input  logic      dsr_wr,
   input  logic      wr_hi,
   input  hi_flags_t wr_data,
   output hi_flags_t hi_q,
   output logic      irq
);

   hi_flags_t hi_d;
   logic      drop_master_q;
   logic      drop_master_d;
   logic      fall_now;

   always_comb begin
      hi_d          = hi_q;
      drop_master_d = drop_master_q;

      // CPU writes first, so every hardware rule below takes precedence.
      if (wr_hi) begin
         hi_d.pend_n = wr_data.pend_n;
         hi_d.dir_tx = wr_data.dir_tx;
         hi_d.master = wr_data.master;
         if (hi_q.master && hi_q.dir_tx) hi_d.busy = wr_data.busy;
      end
      if (dsr_wr) hi_d.pend_n = 1'b1;

      if (start_det) hi_d.busy = 1'b1;
      if (stop_det)  hi_d.busy = 1'b0;

      if (addr_take)                                hi_d.dir_tx = addr_rw;
      if (start_req && hi_q.busy)                   hi_d.dir_tx = 1'b0;
      if (stop_det)                                 hi_d.dir_tx = 1'b0;
      if (!hi_q.master && (start_det || no_ack))    hi_d.dir_tx = 1'b0;
      if (arb_take) begin
         hi_d.dir_tx   = 1'b0;
         drop_master_d = 1'b1;
      end

      if (ev_byte_end) begin
         hi_d.pend_n = 1'b0;
         if (drop_master_q || arb_take) hi_d.master = 1'b0;
         drop_master_d = 1'b0;
      end

      if (!iface_en) begin
         hi_d.pend_n = 1'b1;
         hi_d.busy   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q          <= HI_RESET;
         drop_master_q <= 1'b0;
      end else begin
         hi_q          <= hi_d;
         drop_master_q <= drop_master_d;
      end
   end

   assign fall_now = hi_q.pend_n & ~hi_d.pend_n;

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= fall_now;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = fall_now;
      end
   endgenerate

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
   import i2c_status_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              iface_en,
   input  logic              ev_byte_end,
   input  logic              ev_ack,
   input  logic              ack_level,
   input  logic              ev_rx_last,
   input  logic              rx_bit,
   input  logic              ack_mode,
   input  logic              ev_arb_lost,
   input  logic              ev_addr_match,
   input  logic              ev_gen_call,
   input  logic              addr_rw,
   input  logic              start_req,
   input  logic              dsr_wr,
   input  logic              wr_hi,
   input  logic [FLAG_W-1:0] wr_hi_data,
   output logic [FLAG_W-1:0] lo_flags,
   output logic [FLAG_W-1:0] hi_flags,
   output logic              irq,
   output logic              scl_hold
);

   logic      start_det;
   logic      stop_det;
   lo_flags_t lo_q;
   hi_flags_t hi_q;
   logic      arb_take;
   logic      addr_take;
   logic      gcall_take;
   logic      no_ack;

   i2c_bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // Event qualification shared by both flag groups.
   assign arb_take   = ev_arb_lost & hi_q.master & hi_q.dir_tx;
   assign addr_take  = ev_addr_match & ~hi_q.master;
   assign gcall_take = ev_gen_call & ~hi_q.master;
   assign no_ack     = ev_ack & ack_level;

   i2c_lo_flag_unit u_lo (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .ack_mode   (ack_mode),
      .ev_ack     (ev_ack),
      .ack_level  (ack_level),
      .ev_rx_last (ev_rx_last),
      .rx_bit     (rx_bit),
      .arb_take   (arb_take),
      .addr_take  (addr_take),
      .gcall_take (gcall_take),
      .dsr_wr     (dsr_wr),
      .lo_q       (lo_q)
   );

   i2c_hi_flag_unit #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_hi (
      .clk         (clk),
      .rst_n       (rst_n),
      .iface_en    (iface_en),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .start_req   (start_req),
      .ev_byte_end (ev_byte_end),
      .no_ack      (no_ack),
      .arb_take    (arb_take),
      .addr_take   (addr_take),
      .addr_rw     (addr_rw),
      .dsr_wr      (dsr_wr),
      .wr_hi       (wr_hi),
      .wr_data     (hi_flags_t'(wr_hi_data)),
      .hi_q        (hi_q),
      .irq         (irq)
   );

   assign lo_flags = lo_q;
   assign hi_flags = hi_q;
   assign scl_hold = iface_en & ~hi_q.pend_n;

endmodule

// File: rtl/i2c_status_flags_chk.sv
module i2c_status_flags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       iface_en,
   input logic       ev_byte_end,
   input logic       ev_ack,
   input logic       ev_rx_last,
   input logic       ack_mode,
   input logic       dsr_wr,
   input logic [3:0] lo_flags,
   input logic [3:0] hi_flags,
   input logic       irq,
   input logic       scl_hold
);

   assert_irq_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!hi_flags[3] && $past(hi_flags[3])));

   assert_hold_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !hi_flags[3]);

   assert_idle_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !iface_en |=> !hi_flags[2]);

   assert_dsr_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_wr && iface_en && !ev_byte_end) |=> hi_flags[3]);

   assert_dsr_clears_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_wr && !(ev_ack && ack_mode) && !(ev_rx_last && !ack_mode)) |=> !lo_flags[3]);

   assert_arb_forces_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_flags[0]) |-> !hi_flags[1]);

endmodule

bind i2c_status_flags i2c_status_flags_chk chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .iface_en    (iface_en),
   .ev_byte_end (ev_byte_end),
   .ev_ack      (ev_ack),
   .ev_rx_last  (ev_rx_last),
   .ack_mode    (ack_mode),
   .dsr_wr      (dsr_wr),
   .lo_flags    (lo_flags),
   .hi_flags    (hi_flags),
   .irq         (irq),
   .scl_hold    (scl_hold)
);

// File: tb/i2c_status_flags_test.sv
`timescale 1ns/1ps
module i2c_status_flags_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1, iface_en = 1'b1;
   logic       ev_byte_end = 0, ev_ack = 0, ack_level = 0, ev_rx_last = 0, rx_bit = 0;
   logic       ack_mode = 0, ev_arb_lost = 0, ev_addr_match = 0, ev_gen_call = 0, addr_rw = 0;
   logic       start_req = 0, dsr_wr = 0, wr_hi = 0;
   logic [3:0] wr_hi_data = 4'h0;
   logic [3:0] lo_flags, hi_flags;
   logic       irq, scl_hold;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_status_flags uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .iface_en(iface_en),
      .ev_byte_end(ev_byte_end), .ev_ack(ev_ack), .ack_level(ack_level),
      .ev_rx_last(ev_rx_last), .rx_bit(rx_bit), .ack_mode(ack_mode),
      .ev_arb_lost(ev_arb_lost), .ev_addr_match(ev_addr_match), .ev_gen_call(ev_gen_call),
      .addr_rw(addr_rw), .start_req(start_req), .dsr_wr(dsr_wr), .wr_hi(wr_hi),
      .wr_hi_data(wr_hi_data), .lo_flags(lo_flags), .hi_flags(hi_flags),
      .irq(irq), .scl_hold(scl_hold)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_hi(input logic [3:0] d);
      wr_hi = 1'b1; wr_hi_data = d;
      tick(); wr_hi = 1'b0;
   endtask

   task automatic write_dsr();
      dsr_wr = 1'b1; tick(); dsr_wr = 1'b0;
   endtask

   task automatic byte_end();
      ev_byte_end = 1'b1; tick(); ev_byte_end = 1'b0;
   endtask

   task automatic bus_start();
      sda_in = 1'b0; tick(6);
   endtask

   task automatic bus_stop();
      scl_in = 1'b0; tick(2); sda_in = 1'b0; tick(2);
      scl_in = 1'b1; tick(3); sda_in = 1'b1; tick(6);
   endtask

   task automatic t_reset();
      check("R1 low flags", lo_flags, 4'b0000);
      check("R1 high flags", hi_flags, 4'b1000);
      check("R1 irq/hold", {2'b00, irq, scl_hold}, 4'b0000);
   endtask

   task automatic t_busy();
      bus_start();
      check("R2 start sets busy", hi_flags, 4'b1100);
      bus_stop();
      check("R2 stop clears busy", hi_flags, 4'b1000);
      iface_en = 1'b0; tick();
      bus_start();
      check("R2 busy held low while disabled", hi_flags, 4'b1000);
      iface_en = 1'b1; bus_stop();
   endtask

   task automatic t_byte_irq();
      byte_end();
      check("R4 pending cleared", hi_flags, 4'b0000);
      check("R4 irq and hold", {2'b00, irq, scl_hold}, 4'b0011);
      tick();
      check("R4 irq single cycle", {3'b000, irq}, 4'b0000);
      write_dsr();
      check("R5 dsr write releases", {hi_flags[3], 2'b00, scl_hold}, 4'b1000);
      byte_end();
      iface_en = 1'b0; tick(); iface_en = 1'b1;
      check("R5 disable releases", hi_flags, 4'b1000);
   endtask

   task automatic t_lastbit();
      ack_mode = 1'b1;
      ev_ack = 1'b1; ack_level = 1'b1; tick(); ev_ack = 1'b0;
      check("R3 no ack sets last bit", lo_flags, 4'b1000);
      ev_ack = 1'b1; ack_level = 1'b0; tick(); ev_ack = 1'b0;
      check("R3 ack clears last bit", lo_flags, 4'b0000);
      ev_ack = 1'b1; ack_level = 1'b1; tick(); ev_ack = 1'b0;
      write_dsr();
      check("R3 dsr write clears last bit", lo_flags, 4'b0000);
      ev_rx_last = 1'b1; rx_bit = 1'b1; tick(); ev_rx_last = 1'b0;
      check("R3 data bit ignored in ack mode", lo_flags, 4'b0000);
      ack_mode = 1'b0;
      ev_rx_last = 1'b1; rx_bit = 1'b1; tick(); ev_rx_last = 1'b0;
      check("R3 data bit loaded", lo_flags, 4'b1000);
      ev_ack = 1'b1; ack_level = 1'b0; tick(); ev_ack = 1'b0;
      check("R3 ack ignored outside ack mode", lo_flags, 4'b1000);
      ack_level = 1'b0;
      write_dsr();
   endtask

   task automatic t_arb();
      write_hi(4'b1011);
      ev_arb_lost = 1'b1; tick(); ev_arb_lost = 1'b0;
      check("R6 arb flag set", lo_flags, 4'b0001);
      check("R6 receive forced, master kept", hi_flags, 4'b1001);
      byte_end();
      check("R6 master drops at byte end", hi_flags, 4'b0000);
      write_dsr();
      check("R6 dsr clears arb flag", lo_flags, 4'b0000);
      ev_arb_lost = 1'b1; tick(); ev_arb_lost = 1'b0;
      check("R6 arb ignored as slave", lo_flags, 4'b0000);
   endtask

   task automatic t_addr();
      write_hi(4'b1000);
      ev_addr_match = 1'b1; addr_rw = 1'b1; tick(); ev_addr_match = 1'b0;
      check("R7 address hit", lo_flags, 4'b0010);
      check("R7 rw loads direction", hi_flags, 4'b1010);
      write_dsr();
      check("R7 dsr clears address hit", lo_flags, 4'b0000);
      ev_gen_call = 1'b1; tick(); ev_gen_call = 1'b0;
      check("R7 general call", lo_flags, 4'b0110);
      bus_start();
      check("R7 start clears general call", lo_flags, 4'b0010);
      check("R8 start clears direction as slave", hi_flags, 4'b1100);
      write_hi(4'b1010);
      check("R9 write sets direction", hi_flags, 4'b1110);
      bus_stop();
      check("R8 stop clears direction", hi_flags, 4'b1000);
      write_dsr();
   endtask

   task automatic t_dir();
      write_hi(4'b1010);
      ev_ack = 1'b1; ack_level = 1'b1; tick(); ev_ack = 1'b0;
      check("R8 no ack clears direction", hi_flags, 4'b1000);
      write_hi(4'b1011);
      write_hi(4'b1111);
      check("R9 busy writable in master transmit", hi_flags, 4'b1111);
      start_req = 1'b1; tick(); start_req = 1'b0;
      check("R8 blocked start clears direction", hi_flags, 4'b1101);
      write_hi(4'b1000);
      check("R9 busy write ignored", hi_flags, 4'b1100);
      iface_en = 1'b0; tick(); iface_en = 1'b1;
      write_dsr();
   endtask

   task automatic t_collide();
      ev_byte_end = 1'b1; wr_hi = 1'b1; wr_hi_data = 4'b1000; tick();
      ev_byte_end = 1'b0; wr_hi = 1'b0;
      check("R9 byte end beats pending write", hi_flags, 4'b0000);
      ev_byte_end = 1'b1; dsr_wr = 1'b1; tick();
      ev_byte_end = 1'b0; dsr_wr = 1'b0;
      check("R9 byte end beats dsr write", {hi_flags[3], 3'b000}, 4'b0000);
      ev_rx_last = 1'b1; rx_bit = 1'b1; dsr_wr = 1'b1; tick();
      ev_rx_last = 1'b0; dsr_wr = 1'b0;
      check("R9 data bit beats dsr clear", {lo_flags[3], 3'b000}, 4'b1000);
   endtask

   initial begin
      fork
         begin
            tick(3); rst_n = 1'b1; tick();
            t_reset();
            t_busy();
            t_byte_irq();
            t_lastbit();
            t_arb();
            t_addr();
            t_dir();
            t_collide();
            done = 1'b1;
         end
         begin
            for (int i = 0; i < 20000; i++) begin
               if (!done) @(negedge clk);
            end
            if (!done) begin
               errors++; checks++;
               $display("FAIL watchdog: actual hung expected done");
            end
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule